// File: doc/BRIEF.md
# Barrier Synchronization Counter

This block brings a fixed group of requesters together at a common synchronization point. A participant announces that it has reached the point by pulsing its own arrive bit for one cycle. It then waits until the block signals that the episode is complete. Internally a down-counter starts at the participant total. Every distinct arrival takes one off the counter as a single indivisible step, and several arrivals in the same cycle are all subtracted together. When the counter would reach zero, the block pulses a release output and flips a sense bit. In the same cycle it reloads the counter and forgets who has arrived, so the next episode can start on the very next clock.

A waiting participant can watch either the one-cycle release pulse or the sense level. The sense level changes once per episode, so a requester that stored the sense value at arrival simply waits until the level differs. An arrival that comes right after a release belongs to the new episode and cannot be mistaken for one from the old episode. Only ports whose index is below the configured total take part. A second arrival from the same port within one episode is dropped and sets a sticky error flag. The participant total can be changed through a small configuration port, but only while no arrival is outstanding. Each request is answered one cycle later with either an accept pulse or a refuse pulse.

The interface has no data flow, so there is no valid/ready channel and no back-pressure. All pins are plain control and status, sampled on the rising clock, and the reset is asynchronous and active low.

Top module: `barrier_sync`

## Requirements
- R1: After reset, release, sense, error, accept and refuse outputs are 0, and the participant total equals the INIT_COUNT parameter (default 8).
- R2: The release pulse is never raised before every participating port has arrived in the current episode.
- R3: Arrive pulses from several distinct participating ports in the same cycle are all counted in that cycle.
- R4: The release output is high for exactly one cycle, in the cycle after the clock edge at which the last missing arrival was sampled.
- R5: The sense output toggles exactly at each release and holds its value otherwise.
- R6: An arrive from a port that has already arrived in the current episode is not counted. It sets the error output, which then stays 1 until reset.
- R7: The counter reloads to the participant total at the release edge, so an arrival sampled in the following cycle counts toward the next episode.
- R8: An arrive from a port whose index is not below the participant total is ignored and does not set the error output.
- R9: A configuration request whose value is between 1 and N_PORTS is accepted if no participant has arrived in the current episode and no participating arrival is sampled in the same cycle. An accepted request raises the accept output for one cycle after the edge and makes the value the new participant total.
- R10: Any other configuration request (out of range, an arrival outstanding, or an arrival in the same cycle) raises the refuse output for one cycle and leaves the total and the episode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arrive_i | input | N_PORTS | One-cycle arrive pulse per port |
| cfg_valid_i | input | 1 | Participant total change request |
| cfg_count_i | input | CNT_W | Requested participant total |
| release_o | output | 1 | One-cycle episode completion pulse |
| sense_o | output | 1 | Episode sense level, toggles at each release |
| dup_err_o | output | 1 | Sticky duplicate-arrival flag |
| cfg_ack_o | output | 1 | Configuration accepted (one cycle) |
| cfg_nak_o | output | 1 | Configuration refused (one cycle) |

## Verification
The main function is tried with several arrival patterns. Strictly one-at-a-time arrivals check that every decrement is counted. All ports arriving in one cycle shows that a simultaneous group is not collapsed into a single decrement. Mixed groups containing a repeat separate the duplicate rule from plain counting. An arrival in the cycle directly after a release tells the episode boundary apart from an off-by-one reload. Configuration requests are tried mid-episode, in the same cycle as an arrival, out of range and while idle. A reduced total is then exercised with a non-participating port, to show that the participant mask follows the new total.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

  typedef enum logic [1:0] {
    CFG_NONE    = 2'd0,
    CFG_TAKEN   = 2'd1,
    CFG_REFUSED = 2'd2
  } cfg_verdict_e;

endpackage

// File: rtl/bar_popcount.sv
module bar_popcount #(
  parameter int W  = 8,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [OW-1:0] count_o
);

  logic [OW-1:0] partial [W+1];

  assign partial[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_sum
    assign partial[i+1] = partial[i] + OW'(bits_i[i]);
  end

  assign count_o = partial[W];

endmodule

// File: rtl/bar_arrival_filter.sv
module bar_arrival_filter #(
  parameter int N_PORTS = 8,
  parameter int CNT_W   = $clog2(N_PORTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] arrive_i,
  input  logic [CNT_W-1:0]   total_i,
  input  logic               release_now_i,
  output logic [N_PORTS-1:0] new_mask_o,
  output logic [N_PORTS-1:0] arrived_o,
  output logic               dup_err_o
);

  logic [N_PORTS-1:0] member;
  logic [N_PORTS-1:0] arrived_q;
  logic               err_q;
  logic               dup_hit;

  // a port takes part when its index is below the configured total
  for (genvar i = 0; i < N_PORTS; i++) begin : g_member
    assign member[i] = (CNT_W'(i) < total_i);
  end

  assign new_mask_o = arrive_i & member & ~arrived_q;
  assign dup_hit    = |(arrive_i & member & arrived_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arrived_q <= '0;
      err_q     <= 1'b0;
    end else begin
      arrived_q <= release_now_i ? '0 : (arrived_q | new_mask_o);
      err_q     <= err_q | dup_hit;
    end
  end

  assign arrived_o = arrived_q;
  assign dup_err_o = err_q;

  // R6: once raised the flag never drops
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err_o |=> dup_err_o);

  // R6: a recorded arrival is kept until the release clears the episode
  a_r6_arrival_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !release_now_i |=> ((arrived_q & $past(arrived_q)) == $past(arrived_q)));

  // R8: non-participating ports never appear as arrived
  a_r8_only_members: assert property (@(posedge clk) disable iff (!rst_n)
    (arrived_q & ~member) == '0);

endmodule

// File: rtl/bar_episode_ctrl.sv
module bar_episode_ctrl
  import barrier_pkg::*;
#(
  parameter int N_PORTS    = 8,
  parameter int CNT_W      = $clog2(N_PORTS + 1),
  parameter int INIT_COUNT = N_PORTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] new_cnt_i,
  input  logic             idle_i,
  input  logic             cfg_valid_i,
  input  logic [CNT_W-1:0] cfg_count_i,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] remaining_o,
  output logic             release_now_o,
  output logic             release_o,
  output logic             sense_o,
  output logic             cfg_ack_o,
  output logic             cfg_nak_o
);

  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(N_PORTS);
  localparam logic [CNT_W-1:0] INIT_CNT = CNT_W'(INIT_COUNT);

  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] remaining_q;
  logic [CNT_W-1:0] rem_after;
  logic             rel_q;
  logic             sense_q;
  logic             cfg_ok;
  cfg_verdict_e     verdict_d;
  cfg_verdict_e     verdict_q;

  // fetch-and-add of minus the group size
  assign rem_after     = remaining_q - new_cnt_i;
  assign release_now_o = (new_cnt_i != '0) && (rem_after == '0);

  assign cfg_ok = cfg_valid_i && idle_i && (new_cnt_i == '0) &&
                  (cfg_count_i != '0) && (cfg_count_i <= MAX_CNT);

  always_comb begin
    verdict_d = CFG_NONE;
    if (cfg_valid_i) verdict_d = cfg_ok ? CFG_TAKEN : CFG_REFUSED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q     <= INIT_CNT;
      remaining_q <= INIT_CNT;
      rel_q       <= 1'b0;
      sense_q     <= 1'b0;
      verdict_q   <= CFG_NONE;
    end else begin
      rel_q     <= release_now_o;
      verdict_q <= verdict_d;
      if (release_now_o) begin
        remaining_q <= total_q;
        sense_q     <= ~sense_q;
      end else if (cfg_ok) begin
        total_q     <= cfg_count_i;
        remaining_q <= cfg_count_i;
      end else begin
        remaining_q <= rem_after;
      end
    end
  end

  assign total_o     = total_q;
  assign remaining_o = remaining_q;
  assign release_o   = rel_q;
  assign sense_o     = sense_q;
  assign cfg_ack_o   = (verdict_q == CFG_TAKEN);
  assign cfg_nak_o   = (verdict_q == CFG_REFUSED);

  // R2: the counter never sits at zero and never exceeds the total
  a_r2_count_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining_q != '0) && (remaining_q <= total_q));

  // R5: sense flips with each release
  a_r5_sense_flip: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> (sense_o != $past(sense_o)));

  // R5: sense holds between releases
  a_r5_sense_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !release_o |-> (sense_o == $past(sense_o)));

  // R7: a fresh episode starts from the full total
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> (remaining_q == total_q));

  // R9: accept and refuse are exclusive
  a_r9_verdict_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ack_o && cfg_nak_o));

  // R10: the total only moves on an accepted request
  a_r10_total_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (total_q != $past(total_q)) |-> cfg_ack_o);

endmodule

// File: rtl/barrier_sync.sv
module barrier_sync #(
  parameter int N_PORTS    = 8,
  parameter int INIT_COUNT = N_PORTS,
  parameter int CNT_W      = $clog2(N_PORTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] arrive_i,
  input  logic               cfg_valid_i,
  input  logic [CNT_W-1:0]   cfg_count_i,
  output logic               release_o,
  output logic               sense_o,
  output logic               dup_err_o,
  output logic               cfg_ack_o,
  output logic               cfg_nak_o
);

  logic [N_PORTS-1:0] new_mask;
  logic [N_PORTS-1:0] arrived;
  logic [CNT_W-1:0]   new_cnt;
  logic [CNT_W-1:0]   arrived_cnt;
  logic [CNT_W-1:0]   total;
  logic [CNT_W-1:0]   remaining;
  logic               release_now;

  bar_arrival_filter #(.N_PORTS(N_PORTS), .CNT_W(CNT_W)) u_filter (
    .clk           (clk),
    .rst_n         (rst_n),
    .arrive_i      (arrive_i),
    .total_i       (total),
    .release_now_i (release_now),
    .new_mask_o    (new_mask),
    .arrived_o     (arrived),
    .dup_err_o     (dup_err_o)
  );

  bar_popcount #(.W(N_PORTS), .OW(CNT_W)) u_new_cnt (
    .bits_i  (new_mask),
    .count_o (new_cnt)
  );

  bar_popcount #(.W(N_PORTS), .OW(CNT_W)) u_arr_cnt (
    .bits_i  (arrived),
    .count_o (arrived_cnt)
  );

  bar_episode_ctrl #(.N_PORTS(N_PORTS), .CNT_W(CNT_W), .INIT_COUNT(INIT_COUNT)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .new_cnt_i     (new_cnt),
    .idle_i        (arrived == '0),
    .cfg_valid_i   (cfg_valid_i),
    .cfg_count_i   (cfg_count_i),
    .total_o       (total),
    .remaining_o   (remaining),
    .release_now_o (release_now),
    .release_o     (release_o),
    .sense_o       (sense_o),
    .cfg_ack_o     (cfg_ack_o),
    .cfg_nak_o     (cfg_nak_o)
  );

  // R3: the counter always equals total minus the distinct arrivals so far
  a_r3_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    remaining == (total - arrived_cnt));

  // R2: a release follows only an edge that saw the last missing arrivals
  a_r2_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> ($past(remaining) == $past(new_cnt)));

endmodule

// File: tb/tb_barrier_sync.sv
module tb_barrier_sync;

  localparam int NP = 8;
  localparam int CW = $clog2(NP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] arrive = '0;
  logic          cfg_valid = 1'b0;
  logic [CW-1:0] cfg_count = '0;
  logic          release_w, sense_w, err_w, ack_w, nak_w;

  int total_chk = 0;
  int bad_chk   = 0;
  bit finished  = 0;

  // reference model state
  int m_total = NP;
  int m_rem   = NP;
  bit m_arr [NP];
  bit m_sense = 0, m_err = 0, m_rel = 0, m_ack = 0, m_nak = 0;

  always #5 clk = ~clk;

  barrier_sync #(.N_PORTS(NP)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .arrive_i    (arrive),
    .cfg_valid_i (cfg_valid),
    .cfg_count_i (cfg_count),
    .release_o   (release_w),
    .sense_o     (sense_w),
    .dup_err_o   (err_w),
    .cfg_ack_o   (ack_w),
    .cfg_nak_o   (nak_w)
  );

  task automatic check(input string req, input int act, input int exp);
    total_chk++;
    if (act != exp) begin
      bad_chk++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic [NP-1:0] a, input bit cv, input int cc);
    int  k = 0;
    bit  idle = 1;
    for (int i = 0; i < NP; i++) if (m_arr[i]) idle = 0;
    m_rel = 0; m_ack = 0; m_nak = 0;
    for (int i = 0; i < NP; i++) begin
      if (a[i] && i < m_total) begin
        if (m_arr[i]) m_err = 1;
        else begin m_arr[i] = 1; k++; end
      end
    end
    if (k > 0) begin
      m_rem -= k;
      if (m_rem == 0) begin
        m_rel = 1; m_sense = ~m_sense; m_rem = m_total;
        for (int i = 0; i < NP; i++) m_arr[i] = 0;
      end
    end
    if (cv) begin
      if (idle && k == 0 && cc >= 1 && cc <= NP) begin
        m_ack = 1; m_total = cc; m_rem = cc;
      end else m_nak = 1;
    end
  endtask

  task automatic compare_all();
    check("R2/R3/R4/R7/R8 release", int'(release_w), int'(m_rel));
    check("R5 sense", int'(sense_w), int'(m_sense));
    check("R6 dup_err", int'(err_w), int'(m_err));
    check("R9 cfg_ack", int'(ack_w), int'(m_ack));
    check("R10 cfg_nak", int'(nak_w), int'(m_nak));
  endtask

  task automatic step(input logic [NP-1:0] a, input bit cv = 0, input int cc = 0);
    arrive    = a;
    cfg_valid = cv;
    cfg_count = CW'(cc);
    @(posedge clk);
    model_edge(a, cv, cc);
    @(negedge clk);
    compare_all();
    arrive    = '0;
    cfg_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NP; i++) m_arr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 release", int'(release_w), 0);
    check("R1 sense", int'(sense_w), 0);
    check("R1 dup_err", int'(err_w), 0);
    check("R1 ack/nak", int'(ack_w | nak_w), 0);

    // R1 R2 R4: one at a time with gaps; release only after port 7 (total 8)
    for (int i = 0; i < NP; i++) begin
      step(NP'(1) << i);
      step('0);
    end
    step('0);

    // R3: every port in the same cycle
    step('1);
    step('0);

    // R3 R6: groups with a repeat inside one episode
    step(8'b0000_0111);
    step(8'b0011_1100);
    step(8'b0000_0001);
    step(8'b1100_0000);
    step('0);

    // R7: early arrival right after the release belongs to the next episode
    step(8'b0111_1111);
    step(8'b1000_0000);
    step(8'b0000_0001);
    step(8'b1111_1110);
    step('0);

    // R10: refused while outstanding, alongside an arrival, or out of range
    step(8'b0000_0011);
    step('0, 1, 4);
    step(8'b1111_1100);
    step(8'b0000_0001, 1, 4);
    step(8'b1111_1110);
    step('0, 1, 0);
    step('0, 1, 9);
    step('0);

    // R9 R8: accepted total of 3; port 5 then ignored
    step('0, 1, 3);
    step(8'b0010_0000);
    step(8'b0000_0011);
    step(8'b1000_0100);
    step('0);
    step(8'b0000_0111);
    step('0);

    // R9: back to the full group, last episode
    step('0, 1, 8);
    step(8'b0000_1111);
    step(8'b1111_0000);
    step('0);
    step('0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total_chk++;
      bad_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  end

endmodule